// File: doc/BRIEF.md
# Four-Function Arithmetic Logic Unit with Condition Flags

This block is a combinational arithmetic logic unit for 64-bit words. It takes two operand words and a 2-bit function code, and it returns one result word and three condition flags. There is no clock, no register and no handshake. The outputs follow any change on the operands or on the function code after the gate delay. A condition-code register placed after the block can latch the flags.

The function code selects one of four operations: addition, subtraction, bitwise AND or bitwise XOR. Addition and subtraction share one adder. For subtraction the second operand is inverted and a carry of one is fed in. The zero flag is valid for every operation. The signed overflow flag and the carry flag have meaning only for the two arithmetic operations, and for the two logical operations they are held at 0.

Top module: `alu4_flags`

## Requirements
- R1: With op_sel = 2'd0, result equals opnd_x + opnd_y modulo 2^64.
- R2: With op_sel = 2'd1, result equals opnd_x - opnd_y modulo 2^64.
- R3: With op_sel = 2'd2, result is the bitwise AND of opnd_x and opnd_y.
- R4: With op_sel = 2'd3, result is the bitwise XOR of opnd_x and opnd_y.
- R5: flag_zero is 1 exactly when all 64 bits of result are 0, for every op_sel value.
- R6: For op_sel 0 and 1, flag_ovf is 1 exactly when the true signed two's-complement sum or difference does not fit in 64 bits.
- R7: For op_sel 0, flag_carry is the unsigned carry out of bit 63. For op_sel 1, flag_carry is the borrow, which is 1 exactly when opnd_x < opnd_y as unsigned numbers.
- R8: For op_sel 2 and 3, flag_ovf and flag_carry are 0.
- R9: The block has no clock and no stored state. After any input change, result and the flags settle to the new values, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| opnd_x | input | 64 | First operand (minuend for subtract) |
| opnd_y | input | 64 | Second operand (subtrahend for subtract) |
| result | output | 64 | Result word of the selected operation |
| flag_ovf | output | 1 | Signed overflow for add and subtract, 0 otherwise |
| flag_zero | output | 1 | 1 when result is all zeros |
| flag_carry | output | 1 | Carry for add, borrow for subtract, 0 otherwise |

## Verification
The block holds no state, so a wrong internal signal can never linger and is visible on the outputs as soon as the inputs settle. Examples are a subtract that skips the carry-in, a wrong-polarity borrow or a dropped node in the zero-detect tree. Each such fault shows only for operand patterns that reach it. The directed vectors therefore aim at the sign and carry edges: the most negative and most positive values, all-ones words, and equal operands. A long pseudo-random sweep over all four function codes then covers mixed bit patterns.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 64;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 64
) (
  input  logic         sub_en,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         cry_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;

  // Subtract reuses the adder: a + ~b + 1.
  assign b_eff    = b_in ^ {W{sub_en}};
  assign wide_sum = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
  assign sum_o    = wide_sum[W-1:0];

  // Overflow: the effective operands agree in sign but the sum does not.
  assign ovf_o = (a_in[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_in[MSB]);
  // The carry out is inverted into a borrow for subtract.
  assign cry_o = wide_sum[W] ^ sub_en;

  always_comb begin
    if (sub_en) begin
      assert_borrow_R7: assert (cry_o == (a_in < b_in))
        else $error("borrow mismatch");
    end
  end
endmodule

// File: rtl/alu_bitlogic.sv
module alu_bitlogic #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_in[i] & b_in[i];
    assign xor_o[i] = a_in[i] ^ b_in[i];
  end

  always_comb begin
    assert_and_subset_R3: assert ((and_o & ~a_in) == '0 && (and_o & ~b_in) == '0)
      else $error("AND result sets a bit absent from an operand");
    assert_xor_inverse_R4: assert ((xor_o ^ b_in) == a_in)
      else $error("XOR result does not invert");
  end
endmodule

// File: rtl/alu_zero_det.sv
module alu_zero_det #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] vec_in,
  output logic         zero_o
);
  localparam int unsigned LVL   = (W > 1) ? $clog2(W) : 0;
  localparam int unsigned LEAF  = 1 << LVL;
  localparam int unsigned NODES = 2 * LEAF - 1;

  // Balanced OR tree, stored in heap order: node k has children 2k+1 and 2k+2.
  logic [NODES-1:0] node;

  for (genvar i = 0; i < LEAF; i++) begin : g_leaf
    if (i < W) begin : g_real
      assign node[LEAF-1+i] = vec_in[i];
    end else begin : g_pad
      assign node[LEAF-1+i] = 1'b0;
    end
  end

  for (genvar k = 0; k < LEAF - 1; k++) begin : g_inner
    assign node[k] = node[2*k+1] | node[2*k+2];
  end

  assign zero_o = ~node[0];
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
  import alu_pkg::*;
(
  input  logic [1:0]       op_sel,
  input  logic [ALU_W-1:0] opnd_x,
  input  logic [ALU_W-1:0] opnd_y,
  output logic [ALU_W-1:0] result,
  output logic             flag_ovf,
  output logic             flag_zero,
  output logic             flag_carry
);
  alu_op_e          op;
  logic [ALU_W-1:0] as_sum, and_v, xor_v;
  logic             as_ovf, as_cry, arith;

  assign op    = alu_op_e'(op_sel);
  assign arith = op_is_arith(op);

  alu_addsub #(.W(ALU_W)) u_addsub (
    .sub_en (op == OP_SUB),
    .a_in   (opnd_x),
    .b_in   (opnd_y),
    .sum_o  (as_sum),
    .ovf_o  (as_ovf),
    .cry_o  (as_cry)
  );

  alu_bitlogic #(.W(ALU_W)) u_logic (
    .a_in  (opnd_x),
    .b_in  (opnd_y),
    .and_o (and_v),
    .xor_o (xor_v)
  );

  always_comb begin
    unique case (op)
      OP_AND:  result = and_v;
      OP_XOR:  result = xor_v;
      default: result = as_sum;
    endcase
  end

  // The two flags that only have meaning for add and subtract are gated here.
  assign flag_ovf   = arith & as_ovf;
  assign flag_carry = arith & as_cry;

  alu_zero_det #(.W(ALU_W)) u_zero (
    .vec_in (result),
    .zero_o (flag_zero)
  );

  always_comb begin
    assert_zero_flag_R5: assert (flag_zero == (result == '0))
      else $error("zero flag mismatch");
    if (!arith) begin
      assert_logic_flags_clear_R8: assert (!flag_ovf && !flag_carry)
        else $error("ovf/carry set on logic op");
    end
    if (op == OP_ADD) begin
      assert_add_carry_R7: assert (flag_carry == ((opnd_x + opnd_y) < opnd_x))
        else $error("add carry mismatch");
      assert_no_overflow_R6: assert (flag_ovf ==
        ((opnd_x[ALU_W-1] == opnd_y[ALU_W-1]) && (result[ALU_W-1] != opnd_x[ALU_W-1])))
        else $error("add overflow mismatch");
    end
    if (op == OP_SUB) begin
      assert_sub_result_R2: assert (result + opnd_y == opnd_x)
        else $error("difference wrong");
    end
  end
endmodule

// File: tb/tb_alu4_flags.sv
module tb_alu4_flags;
  localparam int unsigned W = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYC = 100000;

  typedef struct {
    logic [W-1:0] res;
    logic         ovf, zf, cf;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic [W-1:0] opnd_x = '0, opnd_y = '0;
  logic [W-1:0] result;
  logic         flag_ovf, flag_zero, flag_carry;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_flags dut (
    .op_sel(op_sel), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .result(result), .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_carry(flag_carry)
  );

  function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] x,
                                 input logic [W-1:0] y, input string tag);
    exp_t e;
    logic [W:0] sw;
    e.tag = tag; e.ovf = 1'b0; e.cf = 1'b0;
    case (op)
      2'd0: begin
        sw = {x[W-1], x} + {y[W-1], y};
        e.res = sw[W-1:0];
        e.ovf = sw[W] ^ sw[W-1];
        e.cf  = (x > ~y);
      end
      2'd1: begin
        sw = {x[W-1], x} - {y[W-1], y};
        e.res = sw[W-1:0];
        e.ovf = sw[W] ^ sw[W-1];
        e.cf  = (x < y);
      end
      2'd2: e.res = x & y;
      default: e.res = x ^ y;
    endcase
    e.zf = (e.res == '0);
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [W-1:0] x,
                       input logic [W-1:0] y, input string tag);
    @(posedge clk);
    #1;
    op_sel = op; opnd_x = x; opnd_y = y;
    sb.push_back(model(op, x, y, tag));
  endtask

  // Monitor: one comparison per pushed item, half a period after the drive.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result !== e.res || flag_ovf !== e.ovf || flag_zero !== e.zf || flag_carry !== e.cf) begin
        errors++;
        $display("FAIL %s: got res=%h of=%b zf=%b cf=%b exp res=%h of=%b zf=%b cf=%b",
                 e.tag, result, flag_ovf, flag_zero, flag_carry, e.res, e.ovf, e.zf, e.cf);
      end
    end
  end

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  initial begin : stim
    logic [W-1:0] lfsr;
    exp_t e;
    // R9 / initial state: all-zero add, checked directly with no clock edge
    #1;
    e = model(2'd0, '0, '0, "R9 idle");
    checks++;
    if (result !== e.res || flag_zero !== 1'b1 || flag_ovf !== 1'b0 || flag_carry !== 1'b0) begin
      errors++;
      $display("FAIL R9 idle: got res=%h zf=%b exp res=%h zf=1", result, flag_zero, e.res);
    end
    // R9: inputs change between clock edges; outputs follow without any edge
    #2;
    op_sel = 2'd3; opnd_x = 64'hF0F0; opnd_y = 64'h0FF0;
    #1;
    checks++;
    if (result !== 64'hFF00 || flag_zero !== 1'b0) begin
      errors++;
      $display("FAIL R9 follow: got res=%h zf=%b exp res=%h zf=0", result, flag_zero, 64'hFF00);
    end

    drive(2'd0, 64'd1, 64'd2, "R1 small add");
    drive(2'd0, ONES, 64'd1, "R7 add carry wraps to zero R5");
    drive(2'd0, MAXP, 64'd1, "R6 add positive overflow");
    drive(2'd0, MINN, MINN, "R6 R7 add negative overflow carry zero");
    drive(2'd0, ONES, ONES, "R7 add carry without overflow");
    drive(2'd1, 64'd5, 64'd5, "R2 R5 sub equal");
    drive(2'd1, 64'd0, 64'd1, "R7 sub borrow");
    drive(2'd1, MINN, 64'd1, "R6 sub negative overflow");
    drive(2'd1, MAXP, ONES, "R6 R7 sub positive overflow with borrow");
    drive(2'd1, 64'd100, 64'd7, "R2 sub no borrow");
    drive(2'd2, 64'hFF00FF00_FF00FF00, 64'h0F0F0F0F_0F0F0F0F, "R3 and pattern");
    drive(2'd2, 64'hAAAAAAAA_AAAAAAAA, 64'h55555555_55555555, "R3 R5 and to zero");
    drive(2'd2, ONES, ONES, "R8 and all ones no flags");
    drive(2'd3, 64'h12345678_9ABCDEF0, 64'h0F0F0F0F_F0F0F0F0, "R4 xor pattern");
    drive(2'd3, MINN, MINN, "R4 R5 xor equal");
    drive(2'd3, MAXP, ONES, "R8 xor flags clear");

    lfsr = 64'hACE1_2468_1357_BDF9;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = lfsr;
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = (i % 7 == 0) ? a : lfsr;
      if (i % 11 == 0) b = ~a;
      drive(2'(i % 4), a, b, "R1 R2 R3 R4 R6 R7 R8 sweep");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule